// File: doc/BRIEF.md
# SPI Master Transmit Engine with Queued Words

This block is a single-clock SPI master. A bus-side write port pushes 8-bit words into a transmit queue. A sequencer moves each word into a shift register and clocks it out MSB first on MOSI. At the same time it collects the bits on MISO into a receive queue, which a bus-side read port drains. Both queues have eight entries and their own occupancy flags. Each queue also has a threshold comparator whose result software can poll or route to an interrupt.

The serial clock comes from a fixed divider of the system clock. After the first word lands in an idle engine, the sequencer waits a fixed start latency and then shifts. A 4-bit suspend setting inserts whole idle serial-clock periods between consecutive words, and a setting of zero runs the words back to back. Chip select stays low across the whole run, suspend gaps included, and rises only when the queue is drained and the final bit is out. A receive word that arrives while the receive queue is full is thrown away and sets a sticky overrun flag.

Top module: `spi_fifo_master`

## Requirements
- R1: The transmit queue holds 8 words. `tx_full` is 1 exactly when 8 words are queued. A write presented while `tx_full` is 1 is dropped and never appears on MOSI.
- R2: `tx_empty` is 1 out of reset and drops to 0 on the clock after a write is accepted. It returns to 1 on the clock after the sequencer loads the last queued word into its shift register, while `busy` is still 1.
- R3: `tx_thr_flag` is 1 when the transmit queue count is less than or equal to `tx_thresh` (3 bits, 0 to 7), and 0 otherwise.
- R4: `rx_thr_flag` is 1 when the receive queue count is strictly greater than `rx_thresh` (3 bits, 0 to 7), and 0 otherwise.
- R5: With default parameters (2 clocks per serial half-period, 6 start ticks of one half-period each), a word written into an idle engine gives its first SCLK rising edge on the 15th clock edge after the edge that accepts the write: 1 load cycle, then 12 start cycles, then 2 low cycles.
- R6: Within a run, consecutive SCLK rising edges are 4 clocks apart. Between the last bit of one word and the first bit of the next, the spacing is 4 + 4*`suspend_gap` clocks. Chip select stays low and SCLK stays low during the gap.
- R7: Words shift MSB first in mode 0. SCLK idles low, MOSI changes only while SCLK falls or is low, and MISO is sampled on each SCLK rise. The byte seen on MOSI equals the written byte.
- R8: `cs_n` goes low when the first word is loaded. It rises only after the final bit's falling edge when the transmit queue is empty. SCLK is 0 whenever `cs_n` is 1.
- R9: A received word enters the receive queue when its last bit is sampled. `rd_data` shows the oldest entry, and `rd_en` removes it. `rx_full` is 1 at 8 entries and `rx_empty` is 1 at 0 entries.
- R10: A received word that completes while `rx_full` is 1 is discarded and sets `overrun`. The flag stays set until `ovr_clr` is pulsed.
- R11: `busy` is 1 from the load of the first word until the final bit completes, and always equals the inverse of `cs_n`.
- R12: After reset: `tx_empty`=1, `tx_full`=0, `rx_empty`=1, `rx_full`=0, `cs_n`=1, `sclk`=0, `busy`=0, `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 8 | Word to transmit |
| rd_en | input | 1 | Remove the oldest receive queue entry |
| rd_data | output | 8 | Oldest receive queue entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| suspend_gap | input | 4 | Idle serial-clock periods between words |
| tx_thresh | input | 3 | Transmit threshold |
| rx_thresh | input | 3 | Receive threshold |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_thr_flag | output | 1 | Transmit count <= threshold |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_thr_flag | output | 1 | Receive count > threshold |
| overrun | output | 1 | Sticky receive overrun |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A wrong queue pointer or count shows up at the ports within one word time. The bytes on MOSI or on `rd_data` come out reordered or repeated, and the threshold and full flags disagree with the number of words written or received. A sequencer timer or bit counter error moves the SCLK rising edges, so the spacing of rises within a word, across a suspend gap, or after the start latency differs from the expected clock counts at the very next edge. Chip-select or busy errors show up as extra `cs_n` rises within one multi-word run.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_SHIFT = 2'd2,
    SEQ_GAP   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_nxt;
  logic             push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    case ({push_ok, pop_ok})
      2'b10:   cnt_nxt = count + CNT_W'(1);
      2'b01:   cnt_nxt = count - CNT_W'(1);
      default: cnt_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      count <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= (cnt_nxt == CNT_W'(DEPTH));
    end
  end

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));

  // R9
  push_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/spi_shift_seq.sv
module spi_shift_seq import spi_fifo_pkg::*; #(
  parameter int W           = 8,
  parameter int HALF_DIV    = 2,
  parameter int START_TICKS = 6,
  parameter int GAP_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_avail,
  input  logic [W-1:0]     tx_word,
  input  logic [GAP_W-1:0] gap,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy
);
  localparam int START_CLKS = START_TICKS * HALF_DIV;
  localparam int GAP_MAX    = ((1 << GAP_W) - 1) * 2 * HALF_DIV;
  localparam int TMR_MAX    = (START_CLKS > GAP_MAX) ? START_CLKS : GAP_MAX;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int BIT_W      = $clog2(W);

  seq_state_t       state;
  logic [TMR_W-1:0] tmr, gap_last;
  logic [BIT_W-1:0] bit_cnt;
  logic [W-1:0]     sh;
  logic [W-2:0]     rx_sh;
  logic             half_done, last_fall;

  assign gap_last = TMR_W'(gap) * TMR_W'(2 * HALF_DIV) - TMR_W'(1);
  assign mosi     = sh[W-1];
  assign rx_word  = {rx_sh, miso};

  always_comb begin
    half_done = (tmr == TMR_W'(HALF_DIV - 1));
    last_fall = (state == SEQ_SHIFT) && half_done && sclk && (bit_cnt == BIT_W'(W - 1));
    rx_push   = (state == SEQ_SHIFT) && half_done && !sclk && (bit_cnt == BIT_W'(W - 1));
    tx_pop    = ((state == SEQ_IDLE) && tx_avail)
             || (last_fall && tx_avail && (gap == '0))
             || ((state == SEQ_GAP) && (tmr == gap_last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      tmr     <= '0;
      bit_cnt <= '0;
      sh      <= '0;
      rx_sh   <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (tx_avail) begin
          sh      <= tx_word;
          cs_n    <= 1'b0;
          busy    <= 1'b1;
          tmr     <= '0;
          bit_cnt <= '0;
          state   <= SEQ_START;
        end
        SEQ_START: if (tmr == TMR_W'(START_CLKS - 1)) begin
          tmr   <= '0;
          state <= SEQ_SHIFT;
        end else tmr <= tmr + TMR_W'(1);
        SEQ_SHIFT: if (half_done) begin
          tmr  <= '0;
          sclk <= !sclk;
          if (!sclk) rx_sh <= rx_word[W-2:0];
          else if (bit_cnt == BIT_W'(W - 1)) begin
            bit_cnt <= '0;
            if (!tx_avail) begin
              state <= SEQ_IDLE;
              cs_n  <= 1'b1;
              busy  <= 1'b0;
            end else if (gap == '0) sh <= tx_word;
            else state <= SEQ_GAP;
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
            sh      <= {sh[W-2:0], 1'b0};
          end
        end else tmr <= tmr + TMR_W'(1);
        SEQ_GAP: if (tmr == gap_last) begin
          tmr   <= '0;
          sh    <= tx_word;
          state <= SEQ_SHIFT;
        end else tmr <= tmr + TMR_W'(1);
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R8
  idle_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R6
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_GAP) |-> (!cs_n && !sclk));

  // R7
  mosi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int W           = 8,
  parameter int DEPTH       = 8,
  parameter int HALF_DIV    = 2,
  parameter int START_TICKS = 6,
  parameter int GAP_W       = 4,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  input  logic             ovr_clr,
  input  logic [GAP_W-1:0] suspend_gap,
  input  logic [THR_W-1:0] tx_thresh,
  input  logic [THR_W-1:0] rx_thresh,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             tx_thr_flag,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             rx_thr_flag,
  output logic             overrun,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [W-1:0]     tx_head, rx_word;
  logic             tx_pop, rx_push;

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_data), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_word_fifo #(.W(W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_word), .pop(rd_en),
    .head(rd_data), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spi_shift_seq #(.W(W), .HALF_DIV(HALF_DIV), .START_TICKS(START_TICKS), .GAP_W(GAP_W)) i_seq (
    .clk(clk), .rst(rst), .tx_avail(!tx_empty), .tx_word(tx_head), .gap(suspend_gap),
    .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  assign tx_thr_flag = (tx_cnt <= CNT_W'(tx_thresh));
  assign rx_thr_flag = (rx_cnt >  CNT_W'(rx_thresh));

  always_ff @(posedge clk) begin
    if (rst)                     overrun <= 1'b0;
    else if (rx_push && rx_full) overrun <= 1'b1;
    else if (ovr_clr)            overrun <= 1'b0;
  end

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> overrun);

  // R4
  rx_thr_chk: assert property (@(posedge clk) disable iff (rst)
    rx_thr_flag |-> !rx_empty);
endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  localparam int HALF = 2;
  localparam int BITP = 2 * HALF;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic [3:0] suspend_gap = '0;
  logic [2:0] tx_thresh = 3'd7, rx_thresh = 3'd7;
  logic tx_empty, tx_full, tx_thr_flag, rx_empty, rx_full, rx_thr_flag;
  logic overrun, busy, sclk, mosi, miso, cs_n;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .ovr_clr(ovr_clr), .suspend_gap(suspend_gap),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_thr_flag(tx_thr_flag), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_thr_flag(rx_thr_flag), .overrun(overrun),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0, wr_cyc = 0, gw = 0;
  logic [7:0] txd [0:15];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] miso_byte(input int k);
    return 8'(k * 37 + 90);
  endfunction

  // Slave model and SCLK monitor, sampled away from the active edge
  int rises [0:1023];
  int nr = 0, nm = 0, sbits = 0, sk = 0, cs_rises = 0, busy_mis = 0;
  logic [7:0] mlog [0:63];
  logic [7:0] s_in = '0, s_out;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  assign miso = s_out[7];

  always @(negedge clk) if (!rst) begin
    if (sclk && !prev_sclk) begin
      if (nr < 1024) rises[nr] = cyc;
      nr++;
      s_in = {s_in[6:0], mosi};
      sbits++;
      if (sbits == 8) begin
        if (nm < 64) mlog[nm] = s_in;
        nm++;
        sbits = 0;
      end
    end
    if (!sclk && prev_sclk) begin
      if (sbits == 0) begin
        sk++;
        s_out = miso_byte(sk);
      end else s_out = {s_out[6:0], 1'b0};
    end
    if (cs_n && !prev_cs) cs_rises++;
    if (busy !== !cs_n) busy_mis++;
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  task automatic clear_log();
    nr = 0; nm = 0; cs_rises = 0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) wr_cyc = cyc;
      wr_en = 1'b1; wr_data = txd[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic read_rx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9 rd_data order", rd_data, miso_byte(base + i));
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_run(input int n, input int g, input string tag);
    int bad = 0;
    chk({tag, " R7 word count on MOSI"}, nm, n);
    for (int i = 0; i < n; i++) chk({tag, " R7 MOSI byte"}, mlog[i], txd[i]);
    for (int i = 0; i + 1 < n * 8; i++) begin
      int expd = ((i % 8) == 7) ? BITP + BITP * g : BITP;
      if (rises[i + 1] - rises[i] != expd) bad++;
    end
    chk({tag, " R6 SCLK rise spacing"}, bad, 0);
    chk({tag, " R8 single cs_n release"}, cs_rises, 1);
    chk({tag, " R8 idle cs_n"}, cs_n, 1);
    chk({tag, " R8 idle sclk"}, sclk, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    s_out = miso_byte(0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 tx_empty", tx_empty, 1);
    chk("R12 tx_full", tx_full, 0);
    chk("R12 rx_empty", rx_empty, 1);
    chk("R12 rx_full", rx_full, 0);
    chk("R12 cs_n", cs_n, 1);
    chk("R12 sclk", sclk, 0);
    chk("R12 busy", busy, 0);
    chk("R12 overrun", overrun, 0);

    // Single word: tx_empty timing, start latency, chip select
    clear_log();
    txd[0] = 8'hA5;
    @(negedge clk); wr_cyc = cyc; wr_en = 1'b1; wr_data = txd[0];
    @(negedge clk); wr_en = 1'b0;
    chk("R2 tx_empty low after write", tx_empty, 0);
    @(negedge clk);
    chk("R2 tx_empty high after load", tx_empty, 1);
    chk("R11 busy while shifting", busy, 1);
    chk("R8 cs_n low after load", cs_n, 0);
    wait_idle();
    chk("R5 start latency", rises[0] - wr_cyc, 16);
    check_run(1, 0, "single");
    read_rx(1, gw); gw += 1;
    chk("R9 rx_empty after read", rx_empty, 1);

    // Three words, long gap: transmit threshold and receive threshold
    clear_log();
    suspend_gap = 4'd15;
    txd[0] = 8'h3C; txd[1] = 8'h81; txd[2] = 8'h7E;
    send(3);
    chk("R2 tx_empty with words queued", tx_empty, 0);
    tx_thresh = 3'd1; #1;
    chk("R3 count 2 > thresh 1", tx_thr_flag, 0);
    tx_thresh = 3'd2; #1;
    chk("R3 count 2 <= thresh 2", tx_thr_flag, 1);
    tx_thresh = 3'd7;
    wait_idle();
    check_run(3, 15, "gap15");
    rx_thresh = 3'd2; #1;
    chk("R4 count 3 > thresh 2", rx_thr_flag, 1);
    rx_thresh = 3'd3; #1;
    chk("R4 count 3 > thresh 3", rx_thr_flag, 0);
    rx_thresh = 3'd7;
    read_rx(3, gw); gw += 3;

    // Overfill: writes 10..12 dropped, 9th received word overruns
    clear_log();
    suspend_gap = 4'd0;
    for (int i = 0; i < 12; i++) txd[i] = 8'($urandom);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 8) begin
        chk("R1 not full at 7 queued", tx_full, 0);
        chk("R3 count 7 <= thresh 7", tx_thr_flag, 1);
      end
      if (i == 9) begin
        chk("R1 full at 8 queued", tx_full, 1);
        chk("R3 count 8 > thresh 7", tx_thr_flag, 0);
      end
      wr_en = 1'b1; wr_data = txd[i];
    end
    @(negedge clk); wr_en = 1'b0;
    wait_idle();
    check_run(9, 0, "R1 overfill");
    chk("R10 overrun set", overrun, 1);
    chk("R9 rx_full at 8", rx_full, 1);
    chk("R4 count 8 > thresh 7", rx_thr_flag, 1);
    read_rx(1, gw);
    chk("R4 count 7 > thresh 7", rx_thr_flag, 0);
    read_rx(7, gw + 1);
    gw += 9;
    chk("R9 rx_empty after drain", rx_empty, 1);
    chk("R10 overrun sticky", overrun, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R10 overrun cleared", overrun, 0);

    // Random bursts
    for (int it = 0; it < 8; it++) begin
      int n = 1 + int'($urandom % 8);
      int g = int'($urandom % 16);
      int thr = int'($urandom % 8);
      clear_log();
      suspend_gap = 4'(g);
      for (int i = 0; i < n; i++) txd[i] = 8'($urandom);
      repeat (int'($urandom % 5)) @(negedge clk);
      send(n);
      wait_idle();
      check_run(n, g, "random");
      rx_thresh = 3'(thr); #1;
      chk("R4 random rx threshold", rx_thr_flag, (n > thr) ? 1 : 0);
      rx_thresh = 3'd7;
      read_rx(n, gw); gw += n;
      chk("R9 random rx_empty", rx_empty, 1);
    end

    chk("R11 busy equals inverse cs_n", busy_mis, 0);
    summary();
    $finish;
  end
endmodule